// File: doc/BRIEF.md
# Multi-Accumulator Multiply-Accumulate Unit

This unit holds four independent accumulators, each made of a HI word and a LO word. It carries out the integer multiply family: plain multiply, multiply-add and multiply-subtract, each in a signed and an unsigned form. It also carries out moves between a general register and either half of an accumulator. The issuing pipeline supplies a decoded opcode, two source operands, two 5-bit fields cut from the instruction word and a flag that says whether DSP extensions are enabled. The unit returns a move-from result together with a destination write enable, and it raises a one-cycle fault when an operation names an extended accumulator while the extensions are disabled.

The accumulator index is taken from a different instruction field depending on the operation. Move-from operations read it from the low two bits of the field at word bits [25:21], so the index sits at word bits [22:21]. Every other operation reads it from the low two bits of the field at word bits [15:11], so the index sits at word bits [12:11]. Every operation completes in one clock, and its outputs are registered. The parameter `REG_W` selects a 32-bit or 64-bit register width. When the width is 64, a move to or from accumulator 1, 2 or 3 sign-extends bit 31, while accumulator 0 passes the full width.

Top module: `mac_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all eight accumulator words, `rdResult`, `rdWrite` and `fault` to zero.
- R2: The opcode encoding is: 0 signed multiply, 1 unsigned multiply, 2 signed multiply-add, 3 unsigned multiply-add, 4 signed multiply-subtract, 5 unsigned multiply-subtract, 6 move-from-HI, 7 move-from-LO, 8 move-to-HI, 9 move-to-LO. Move-from operations take the accumulator index from `instrHiField[1:0]`. All other operations take it from `instrLoField[1:0]`.
- R3: A signed multiply sign-extends both 32-bit operands and an unsigned multiply zero-extends them. The 64-bit product is stored with bits [31:0] in LO and bits [63:32] in HI of the selected accumulator, each half sign-extended to `REG_W`.
- R4: Multiply-add adds the product to the 64-bit value {HI,LO} of the selected accumulator, and multiply-subtract subtracts the product from it. The result is split back into HI and LO as in R3, with the carry or borrow crossing from LO into HI.
- R5: An operation with a non-zero accumulator index while `dspEnable` is low raises `fault` for one cycle. Such an operation changes no accumulator and does not assert `rdWrite`. Accumulator 0 never faults.
- R6: A move-from whose destination field `instrLoField` is zero is a no-op. It gives no `rdWrite`, no `fault` (even with a non-zero index and `dspEnable` low) and no change to `rdResult`.
- R7: A move-to whose source field `instrHiField` is zero writes zero into the selected half, whatever the value of `srcA`. Otherwise the half receives `srcA`.
- R8: Outputs appear in the cycle after the operation is presented. `rdResult` holds its last value until the next move-from. A move-from issued in the cycle right after an update returns the updated value.
- R9: A cycle with `opValid` low, or with an opcode of 10 to 15, changes no accumulator and gives no `rdWrite` and no `fault`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 4 | Decoded operation (encoding in R2) |
| srcA | input | REG_W | First operand; the move-to data |
| srcB | input | REG_W | Second multiply operand |
| instrHiField | input | 5 | Instruction word bits [25:21] |
| instrLoField | input | 5 | Instruction word bits [15:11] |
| dspEnable | input | 1 | Accumulators 1 to 3 may be used |
| rdResult | output | REG_W | Move-from result |
| rdWrite | output | 1 | Destination register write enable |
| fault | output | 1 | Extended accumulator used while disabled |

## Verification
The bench concentrates on the split between the two index fields. To test it, it drives move-from operations whose `instrLoField` low bits differ from the intended index, and moves and multiplies whose `instrHiField` low bits differ. A design that read the wrong field would update or return another accumulator.

Other checks target the carry and borrow between LO and HI in multiply-add and multiply-subtract, and the difference between signed and unsigned products of all-ones operands. A design that confused the two extensions would get HI wrong. Further checks cover:
- a faulting operation: the bench reads the accumulator back afterwards to show it is untouched;
- a move-from to register 0 with extensions disabled: it must stay silent rather than fault;
- a move-to from register 0: it must write zero and not `srcA`.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int NUM_ACC   = 4;
  localparam int ACC_IDX_W = $clog2(NUM_ACC);
  localparam int MUL_W     = 32;

  typedef enum logic [3:0] {
    OP_MUL_S  = 4'd0,
    OP_MUL_U  = 4'd1,
    OP_MADD_S = 4'd2,
    OP_MADD_U = 4'd3,
    OP_MSUB_S = 4'd4,
    OP_MSUB_U = 4'd5,
    OP_RD_HI  = 4'd6,
    OP_RD_LO  = 4'd7,
    OP_WR_HI  = 4'd8,
    OP_WR_LO  = 4'd9
  } macOp_e;

  // Strobes from control to datapath for the operation of this cycle
  typedef struct packed {
    logic                 wrHi;
    logic                 wrLo;
    logic                 isMove;
    logic                 isSigned;
    logic                 accAdd;
    logic                 accSub;
    logic                 rdHi;
    logic                 rdLo;
    logic                 srcZero;
    logic                 fault;
    logic [ACC_IDX_W-1:0] idx;
  } macStrobe_t;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic       opValid,
  input  logic [3:0] opCode,
  input  logic [4:0] instrHiField,
  input  logic [4:0] instrLoField,
  input  logic       dspEnable,
  output macStrobe_t strobe
);
  logic isMulFam, isRead, isMoveTo, readNop, active, denied, go;
  macOp_e op;

  always_comb begin
    op       = macOp_e'(opCode);
    isMulFam = 1'b0;
    isRead   = 1'b0;
    isMoveTo = 1'b0;
    case (op)
      OP_MUL_S, OP_MUL_U, OP_MADD_S, OP_MADD_U, OP_MSUB_S, OP_MSUB_U: isMulFam = 1'b1;
      OP_RD_HI, OP_RD_LO: isRead   = 1'b1;
      OP_WR_HI, OP_WR_LO: isMoveTo = 1'b1;
      default: ;
    endcase

    strobe.idx = isRead ? instrHiField[ACC_IDX_W-1:0] : instrLoField[ACC_IDX_W-1:0];
    readNop    = isRead && (instrLoField == '0);
    active     = opValid && (isMulFam || isMoveTo || (isRead && !readNop));
    denied     = (strobe.idx != '0) && !dspEnable;
    go         = active && !denied;

    strobe.fault    = active && denied;
    strobe.wrHi     = go && (isMulFam || op == OP_WR_HI);
    strobe.wrLo     = go && (isMulFam || op == OP_WR_LO);
    strobe.isMove   = isMoveTo;
    strobe.isSigned = (op == OP_MUL_S) || (op == OP_MADD_S) || (op == OP_MSUB_S);
    strobe.accAdd   = (op == OP_MADD_S) || (op == OP_MADD_U);
    strobe.accSub   = (op == OP_MSUB_S) || (op == OP_MSUB_U);
    strobe.rdHi     = go && op == OP_RD_HI;
    strobe.rdLo     = go && op == OP_RD_LO;
    strobe.srcZero  = (instrHiField == '0);
  end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  macStrobe_t       strobe,
  input  logic [REG_W-1:0] srcA,
  input  logic [REG_W-1:0] srcB,
  output logic [REG_W-1:0] rdResult,
  output logic             rdWrite,
  output logic             fault
);
  localparam int PROD_W = 2 * MUL_W;

  logic [REG_W-1:0] hiQ [NUM_ACC];
  logic [REG_W-1:0] loQ [NUM_ACC];

  logic [PROD_W-1:0] opA, opB, product, base, sum;
  logic [REG_W-1:0]  mvIn, rdRaw, rdVal, hiNew, loNew;

  function automatic logic [REG_W-1:0] sx32(input logic [MUL_W-1:0] v);
    return REG_W'($signed(v));
  endfunction

  always_comb begin
    opA     = {{MUL_W{strobe.isSigned & srcA[MUL_W-1]}}, srcA[MUL_W-1:0]};
    opB     = {{MUL_W{strobe.isSigned & srcB[MUL_W-1]}}, srcB[MUL_W-1:0]};
    product = opA * opB;
    base    = {hiQ[strobe.idx][MUL_W-1:0], loQ[strobe.idx][MUL_W-1:0]};
    if (strobe.accAdd)      sum = base + product;
    else if (strobe.accSub) sum = base - product;
    else                    sum = product;
    rdRaw = strobe.rdHi ? hiQ[strobe.idx] : loQ[strobe.idx];
  end

  // Register-width variant: wide registers narrow extended-accumulator moves
  if (REG_W > MUL_W) begin : g_wide
    always_comb begin
      if (strobe.srcZero)         mvIn = '0;
      else if (strobe.idx != '0)  mvIn = sx32(srcA[MUL_W-1:0]);
      else                        mvIn = srcA;
      rdVal = (strobe.idx != '0) ? sx32(rdRaw[MUL_W-1:0]) : rdRaw;
    end
  end else begin : g_narrow
    always_comb begin
      mvIn  = strobe.srcZero ? '0 : srcA;
      rdVal = rdRaw;
    end
  end

  always_comb begin
    hiNew = strobe.isMove ? mvIn : sx32(sum[PROD_W-1:MUL_W]);
    loNew = strobe.isMove ? mvIn : sx32(sum[MUL_W-1:0]);
  end

  for (genvar k = 0; k < NUM_ACC; k++) begin : g_acc
    always_ff @(posedge clk) begin
      if (rst) begin
        hiQ[k] <= '0;
        loQ[k] <= '0;
      end else begin
        if (strobe.wrHi && strobe.idx == ACC_IDX_W'(k)) hiQ[k] <= hiNew;
        if (strobe.wrLo && strobe.idx == ACC_IDX_W'(k)) loQ[k] <= loNew;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdResult <= '0;
      rdWrite  <= 1'b0;
      fault    <= 1'b0;
    end else begin
      rdWrite <= strobe.rdHi | strobe.rdLo;
      fault   <= strobe.fault;
      if (strobe.rdHi | strobe.rdLo) rdResult <= rdVal;
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             opValid,
  input  logic [3:0]       opCode,
  input  logic [REG_W-1:0] srcA,
  input  logic [REG_W-1:0] srcB,
  input  logic [4:0]       instrHiField,
  input  logic [4:0]       instrLoField,
  input  logic             dspEnable,
  output logic [REG_W-1:0] rdResult,
  output logic             rdWrite,
  output logic             fault
);
  macStrobe_t strobe;

  mac_ctrl i_ctrl (
    .opValid      (opValid),
    .opCode       (opCode),
    .instrHiField (instrHiField),
    .instrLoField (instrLoField),
    .dspEnable    (dspEnable),
    .strobe       (strobe)
  );

  mac_datapath #(.REG_W(REG_W)) i_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .srcA     (srcA),
    .srcB     (srcB),
    .rdResult (rdResult),
    .rdWrite  (rdWrite),
    .fault    (fault)
  );
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       opValid,
  input logic [3:0] opCode,
  input logic [4:0] instrHiField,
  input logic [4:0] instrLoField,
  input logic       dspEnable,
  input logic       rdWrite,
  input logic       fault
);
  // R5: a faulting operation never also writes a destination
  assert_fault_excl_R5: assert property (@(posedge clk) disable iff (rst)
    fault |-> !rdWrite);

  // R5: a fault needs a valid operation with extensions disabled
  assert_fault_cause_R5: assert property (@(posedge clk) disable iff (rst)
    fault |-> $past(opValid && !dspEnable));

  // R5: multiply family on accumulator 0 never faults
  assert_acc0_nofault_R5: assert property (@(posedge clk) disable iff (rst)
    (opValid && opCode <= 4'd5 && instrLoField[1:0] == 2'd0) |=> !fault);

  // R6: move-from to register 0 is silent
  assert_rd_zero_nop_R6: assert property (@(posedge clk) disable iff (rst)
    (opValid && (opCode == 4'd6 || opCode == 4'd7) && instrLoField == 5'd0)
      |=> (!rdWrite && !fault));

  // R9: idle cycles and unused opcodes produce nothing
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (!opValid || opCode > 4'd9) |=> (!rdWrite && !fault));

  // R8: a destination write follows only a move-from one cycle earlier
  assert_write_source_R8: assert property (@(posedge clk) disable iff (rst)
    rdWrite |-> $past(opValid && (opCode == 4'd6 || opCode == 4'd7)));
endmodule

bind mac_unit mac_unit_chk i_mac_unit_chk (
  .clk          (clk),
  .rst          (rst),
  .opValid      (opValid),
  .opCode       (opCode),
  .instrHiField (instrHiField),
  .instrLoField (instrLoField),
  .dspEnable    (dspEnable),
  .rdWrite      (rdWrite),
  .fault        (fault)
);

// File: tb/test_mac_unit.sv
`timescale 1ns/1ps
module test_mac_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        opValid;
  logic [3:0]  opCode;
  logic [31:0] srcA, srcB;
  logic [4:0]  instrHiField, instrLoField;
  logic        dspEnable;
  logic [31:0] rdResult;
  logic        rdWrite, fault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [31:0] mHi [4];
  logic [31:0] mLo [4];
  logic [31:0] expRd;
  logic        expWr, expFault;

  always #2 clk = ~clk;  // 250 MHz

  mac_unit i_mac_unit (
    .clk(clk), .rst(rst), .opValid(opValid), .opCode(opCode),
    .srcA(srcA), .srcB(srcB), .instrHiField(instrHiField),
    .instrLoField(instrLoField), .dspEnable(dspEnable),
    .rdResult(rdResult), .rdWrite(rdWrite), .fault(fault)
  );

  task automatic compare(input string tag);
    checks++;
    if (rdWrite !== expWr || fault !== expFault || rdResult !== expRd) begin
      errors++;
      $display("FAIL %s: actual wr=%0b fault=%0b rd=%h expected wr=%0b fault=%0b rd=%h",
               tag, rdWrite, fault, rdResult, expWr, expFault, expRd);
    end
  endtask

  // Reference behaviour of one operation, applied in program order
  task automatic model(input logic v, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] hf, input logic [4:0] lf,
                       input logic dsp);
    bit isRead  = (op == 6 || op == 7);
    bit isWrite = (op == 8 || op == 9);
    bit isMul   = (op <= 5);
    int idx     = isRead ? int'(hf[1:0]) : int'(lf[1:0]);
    bit act     = v && (isMul || isWrite || (isRead && lf != 0));
    bit flt     = act && idx != 0 && !dsp;
    longint p, acc;
    expWr    = act && !flt && isRead;
    expFault = flt;
    if (expWr) expRd = (op == 6) ? mHi[idx] : mLo[idx];
    if (act && !flt) begin
      if (op == 8) mHi[idx] = (hf == 0) ? 32'd0 : a;
      if (op == 9) mLo[idx] = (hf == 0) ? 32'd0 : a;
      if (isMul) begin
        if (op == 0 || op == 2 || op == 4) p = longint'(int'(a)) * longint'(int'(b));
        else p = longint'({32'd0, a}) * longint'({32'd0, b});
        acc = longint'({mHi[idx], mLo[idx]});
        if (op == 2 || op == 3) acc = acc + p;
        else if (op == 4 || op == 5) acc = acc - p;
        else acc = p;
        mHi[idx] = acc[63:32];
        mLo[idx] = acc[31:0];
      end
    end
  endtask

  task automatic doOp(input logic v, input logic [3:0] op, input logic [31:0] a,
                      input logic [31:0] b, input logic [4:0] hf, input logic [4:0] lf,
                      input logic dsp, input string tag);
    opValid = v; opCode = op; srcA = a; srcB = b;
    instrHiField = hf; instrLoField = lf; dspEnable = dsp;
    model(v, op, a, b, hf, lf, dsp);
    @(negedge clk);
    compare(tag);
  endtask

  // read both halves of accumulator k into the destination register 7
  task automatic readAcc(input int k, input string tag);
    doOp(1, 4'd6, 0, 0, {3'b010, 2'(k)}, 5'd7, 1, tag);
    doOp(1, 4'd7, 0, 0, {3'b011, 2'(k)}, 5'd7, 1, tag);
  endtask

  initial begin
    #(4ns * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin mHi[k] = 0; mLo[k] = 0; end
    expRd = 0; expWr = 0; expFault = 0;
    rst = 1; opValid = 0; opCode = 0; srcA = 0; srcB = 0;
    instrHiField = 0; instrLoField = 0; dspEnable = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    compare("R1 reset outputs");
    for (int k = 0; k < 4; k++) readAcc(k, "R1 accumulators cleared");

    // R7: move-to with data, then from register 0 writes zero
    doOp(1, 4'd8, 32'h1234_5678, 0, 5'd3, 5'b00101, 1, "R7 move-to HI acc1");
    doOp(1, 4'd6, 0, 0, 5'b11101, 5'd4, 1, "R7 read back acc1 HI");
    doOp(1, 4'd8, 32'hDEAD_BEEF, 0, 5'd0, 5'b00101, 1, "R7 zero source");
    doOp(1, 4'd6, 0, 0, 5'b00001, 5'd4, 1, "R7 zero stored");

    // R2: index fields differ between move-from and others
    doOp(1, 4'd9, 32'hA5A5_0002, 0, 5'b00011, 5'b01010, 1, "R2 move-to LO acc2");
    doOp(1, 4'd7, 0, 0, 5'b01110, 5'b01001, 1, "R2 move-from LO acc2 via [22:21]");
    doOp(1, 4'd7, 0, 0, 5'b01101, 5'b01010, 1, "R2 move-from LO acc1 ignores [12:11]");

    // R8: back-to-back update then read
    doOp(1, 4'd9, 32'h0BAD_F00D, 0, 5'd9, 5'b00011, 1, "R8 move-to LO acc3");
    doOp(1, 4'd7, 0, 0, 5'b00011, 5'd2, 1, "R8 read right after update");

    // R3: signed and unsigned products
    doOp(1, 4'd0, 32'hFFFF_FFFD, 32'd7, 5'd1, 5'b10000, 0, "R3 signed mul acc0");
    readAcc(0, "R3 signed product halves");
    doOp(1, 4'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd1, 5'b10011, 1, "R3 unsigned mul acc3");
    readAcc(3, "R3 unsigned product halves");
    doOp(1, 4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd1, 5'b10011, 1, "R3 signed all-ones");
    readAcc(3, "R3 signed all-ones halves");

    // R4: accumulate with carry and borrow across halves
    doOp(1, 4'd9, 32'hFFFF_FFF0, 0, 5'd4, 5'b00010, 1, "R4 preset LO acc2");
    doOp(1, 4'd8, 32'd0, 0, 5'd0, 5'b00010, 1, "R4 preset HI acc2");
    doOp(1, 4'd3, 32'd16, 32'd2, 5'd1, 5'b00010, 1, "R4 unsigned madd carry");
    readAcc(2, "R4 madd carry result");
    doOp(1, 4'd5, 32'd64, 32'd1, 5'd1, 5'b00010, 1, "R4 unsigned msub borrow");
    readAcc(2, "R4 msub borrow result");
    doOp(1, 4'd2, 32'hFFFF_FFFE, 32'd5, 5'd1, 5'b00000, 1, "R4 signed madd");
    doOp(1, 4'd4, 32'h8000_0000, 32'd3, 5'd1, 5'b00000, 1, "R4 signed msub");
    readAcc(0, "R4 signed accumulate result");

    // R5: DSP gate
    doOp(1, 4'd0, 32'd9, 32'd9, 5'd1, 5'b00001, 0, "R5 mul acc1 disabled faults");
    readAcc(1, "R5 acc1 untouched after fault");
    doOp(1, 4'd6, 0, 0, 5'b00010, 5'd3, 0, "R5 move-from acc2 disabled faults");
    doOp(1, 4'd8, 32'h5555_5555, 0, 5'd6, 5'b00011, 0, "R5 move-to acc3 disabled faults");
    readAcc(3, "R5 acc3 untouched after fault");
    doOp(1, 4'd3, 32'd1, 32'd1, 5'd2, 5'b01000, 0, "R5 acc0 needs no DSP");

    // R6: move-from to register 0
    doOp(1, 4'd6, 0, 0, 5'b00010, 5'd0, 0, "R6 silent with idx2 disabled");
    doOp(1, 4'd7, 0, 0, 5'b00000, 5'd0, 1, "R6 silent on acc0");

    // R9: idle and unused opcodes
    doOp(0, 4'd9, 32'h7777_7777, 0, 5'd5, 5'b00000, 1, "R9 opValid low");
    doOp(1, 4'd12, 32'h7777_7777, 0, 5'd5, 5'b00000, 1, "R9 opcode 12");
    doOp(1, 4'd15, 32'h7777_7777, 32'd3, 5'd5, 5'b00000, 0, "R9 opcode 15");
    readAcc(0, "R9 acc0 unchanged");

    // random mixed traffic compared every cycle
    for (int n = 0; n < 2000; n++) begin
      logic [3:0] rop = 4'($urandom_range(0, 11));
      logic [31:0] ra = (($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF - $urandom_range(0, 4) : $urandom);
      doOp(($urandom_range(0, 9) != 0), rop, ra, $urandom, 5'($urandom), 5'($urandom),
           ($urandom_range(0, 3) != 0), "R8 random traffic");
    end
    for (int k = 0; k < 4; k++) readAcc(k, "R8 final state");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule